// File: doc/BRIEF.md
# Sleep-Mode Clock Enable Controller

This block decides, cycle by cycle, which clock branches of a small processor subsystem are running and whether the CPU may fetch instructions. Software asks for one of four power levels: running, or one of three sleep depths. Each level switches off a fixed group of clock enables. The block drives one enable each for the CPU, the main clock, the peripheral (subsystem) clock, the oscillator that sources those two clocks, and the slow auxiliary clock.

Interrupts bring the subsystem back to life. When an interrupt is accepted, the block saves the current level, forces the running level and pulses an acknowledge. A return-from-interrupt strobe then puts back the saved level, so the part drops back to sleep. If the service routine asked for a clear-on-exit, the return lands in the running level instead.

Only the external wake input can revive the deepest level. It passes through a configurable synchronizer. The internal timer wake request is synchronous and works at every level except the deepest. All clock enables are flop outputs.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the level is running (code 00), all five enables are 1 and `irq_ack` is 0.
- R2: Level codes on `mode_req` are 00 running, 01 light sleep, 10 mid sleep and 11 deep sleep. A request with `mode_req_vld` high, made while running and outside interrupt service, sets `cur_mode` at the next clock edge.
- R3: At the running level all five enables are 1. `cpu_en` is 1 only at the running level.
- R4: In light sleep, `cpu_en` and `mclk_en` are 0, and `smclk_en`, `osc_en` and `aclk_en` are 1.
- R5: In mid sleep, only `aclk_en` is 1.
- R6: In deep sleep all five enables are 0. The level can only be left through an accepted interrupt.
- R7: A high level on `irq_ext` is accepted at any level outside service. This happens at the (SYNC_STAGES+1)-th rising edge after it is applied. At that edge `irq_ack` is 1 for exactly one cycle, and the level becomes running with all its enables.
- R8: `irq_int` is accepted at the next edge in running, light and mid sleep. In deep sleep it has no effect.
- R9: A `reti` strobe during service restores the level saved at acceptance, together with that level's enables, at the next edge.
- R10: A `clr_on_exit` strobe during service, either earlier than `reti` or in the same cycle, makes the return resume at the running level.
- R11: During service, further interrupts are not accepted and level requests are ignored.
- R12: `reti` and `clr_on_exit` strobes outside service have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_vld | input | 1 | Level request strobe |
| mode_req | input | 2 | Requested level code |
| irq_ext | input | 1 | External wake interrupt, asynchronous level |
| irq_int | input | 1 | Internal timer wake request, synchronous level |
| reti | input | 1 | Return-from-interrupt strobe |
| clr_on_exit | input | 1 | Resume running on return |
| irq_ack | output | 1 | One-cycle interrupt acceptance pulse |
| cur_mode | output | 2 | Current level code |
| cpu_en | output | 1 | CPU execution enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| osc_en | output | 1 | Fast oscillator enable |
| aclk_en | output | 1 | Auxiliary clock enable |

## Verification
The following results appear one edge after their stimulus:
- level requests
- internal wakes
- returns

An external wake appears three edges after it is applied, with the default of two synchronizer stages. The bench drives every input on a falling edge and samples on a falling edge after the counted number of rising edges. For the external wake it also samples one edge early, to confirm the acknowledge has not yet appeared. Every level is swept against both wake sources and both return styles. The expected enables are computed from the level code.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int PM_W = 2;

   typedef enum logic [PM_W-1:0] {
      PM_RUN   = 2'd0,
      PM_LIGHT = 2'd1,
      PM_MID   = 2'd2,
      PM_DEEP  = 2'd3
   } pm_mode_e;

   typedef struct packed {
      logic cpu;
      logic mclk;
      logic smclk;
      logic osc;
      logic aclk;
   } clk_en_t;

   localparam clk_en_t EN_ALL_ON = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1, osc: 1'b1, aclk: 1'b1};

   function automatic clk_en_t en_of(pm_mode_e m);
      clk_en_t e;
      e.cpu   = (m == PM_RUN);
      e.mclk  = (m == PM_RUN);
      e.smclk = (m == PM_RUN) || (m == PM_LIGHT);
      e.osc   = (m == PM_RUN) || (m == PM_LIGHT);
      e.aclk  = (m != PM_DEEP);
      return e;
   endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= async_in;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign sync_out = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_vld,
   input  pm_mode_e req_mode,
   input  logic     wake_ext,
   input  logic     wake_int,
   input  logic     reti,
   input  logic     clr_on_exit,
   output pm_mode_e mode_q,
   output pm_mode_e mode_nxt,
   output logic     ack_q
);

   pm_mode_e saved_q, saved_d;
   logic     svc_q, svc_d;
   logic     accept;

   assign accept = !svc_q && (wake_ext || (wake_int && mode_q != PM_DEEP));

   always_comb begin
      mode_nxt = mode_q;
      saved_d  = saved_q;
      svc_d    = svc_q;
      if (accept) begin
         saved_d  = mode_q;
         mode_nxt = PM_RUN;
         svc_d    = 1'b1;
      end else if (svc_q && reti) begin
         mode_nxt = clr_on_exit ? PM_RUN : saved_q;
         svc_d    = 1'b0;
      end else if (svc_q && clr_on_exit) begin
         saved_d  = PM_RUN;
      end else if (!svc_q && mode_q == PM_RUN && req_vld) begin
         mode_nxt = req_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PM_RUN;
         saved_q <= PM_RUN;
         svc_q   <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         mode_q  <= mode_nxt;
         saved_q <= saved_d;
         svc_q   <= svc_d;
         ack_q   <= accept;
      end
   end

endmodule

// File: rtl/lpm_en_decode.sv
module lpm_en_decode
   import lpm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pm_mode_e mode_nxt,
   output clk_en_t  en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= EN_ALL_ON;
      end else begin
         en_q <= en_of(mode_nxt);
      end
   end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
   import lpm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_req_vld,
   input  logic [1:0] mode_req,
   input  logic       irq_ext,
   input  logic       irq_int,
   input  logic       reti,
   input  logic       clr_on_exit,
   output logic       irq_ack,
   output logic [1:0] cur_mode,
   output logic       cpu_en,
   output logic       mclk_en,
   output logic       smclk_en,
   output logic       osc_en,
   output logic       aclk_en
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("lpm_clk_ctrl: SYNC_STAGES must lie in 0..4");
      end
      if (PM_W != 2) begin : g_bad_w
         $error("lpm_clk_ctrl: level code must be two bits");
      end
   endgenerate

   logic     ext_s;
   pm_mode_e mode_q, mode_nxt;
   clk_en_t  en_q;

   lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_ext),
      .sync_out (ext_s)
   );

   lpm_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_vld     (mode_req_vld),
      .req_mode    (pm_mode_e'(mode_req)),
      .wake_ext    (ext_s),
      .wake_int    (irq_int),
      .reti        (reti),
      .clr_on_exit (clr_on_exit),
      .mode_q      (mode_q),
      .mode_nxt    (mode_nxt),
      .ack_q       (irq_ack)
   );

   lpm_en_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_nxt (mode_nxt),
      .en_q     (en_q)
   );

   assign cur_mode = mode_q;
   assign cpu_en   = en_q.cpu;
   assign mclk_en  = en_q.mclk;
   assign smclk_en = en_q.smclk;
   assign osc_en   = en_q.osc;
   assign aclk_en  = en_q.aclk;

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_ack,
   input logic [1:0] cur_mode,
   input logic       cpu_en,
   input logic       mclk_en,
   input logic       smclk_en,
   input logic       osc_en,
   input logic       aclk_en
);

   // R7
   ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R7
   ack_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (cur_mode == 2'd0) && cpu_en && mclk_en);

   // R3
   cpu_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_en == (cur_mode == 2'd0));

   // R4
   light_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd1) |-> !mclk_en && smclk_en && osc_en && aclk_en);

   // R5
   mid_aux_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd2) |-> aclk_en && !smclk_en && !osc_en && !mclk_en);

   // R6
   deep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'd3) |-> !(mclk_en || smclk_en || osc_en || aclk_en));

   // R6
   deep_exit_by_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_mode != 2'd3) && ($past(cur_mode) == 2'd3)) |-> irq_ack);

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_ack  (irq_ack),
   .cur_mode (cur_mode),
   .cpu_en   (cpu_en),
   .mclk_en  (mclk_en),
   .smclk_en (smclk_en),
   .osc_en   (osc_en),
   .aclk_en  (aclk_en)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_req_vld = 1'b0;
   logic [1:0] mode_req = 2'd0;
   logic       irq_ext = 1'b0;
   logic       irq_int = 1'b0;
   logic       reti = 1'b0;
   logic       clr_on_exit = 1'b0;
   logic       irq_ack;
   logic [1:0] cur_mode;
   logic       cpu_en, mclk_en, smclk_en, osc_en, aclk_en;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   lpm_clk_ctrl #(.SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
      .irq_ext(irq_ext), .irq_int(irq_int), .reti(reti), .clr_on_exit(clr_on_exit),
      .irq_ack(irq_ack), .cur_mode(cur_mode), .cpu_en(cpu_en), .mclk_en(mclk_en),
      .smclk_en(smclk_en), .osc_en(osc_en), .aclk_en(aclk_en)
   );

   function automatic logic [4:0] exp_en(int m);
      return {m == 0, m == 0, m <= 1, m <= 1, m <= 2};
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk_state(string tag, int m, logic ack);
      chk({tag, " level"}, {6'd0, cur_mode}, 8'(m));
      chk({tag, " enables"}, {3'd0, cpu_en, mclk_en, smclk_en, osc_en, aclk_en}, {3'd0, exp_en(m)});
      chk({tag, " ack"}, {7'd0, irq_ack}, {7'd0, ack});
   endtask

   task automatic request(int m);
      mode_req_vld = 1'b1;
      mode_req = 2'(m);
      tick(1);
      mode_req_vld = 1'b0;
   endtask

   task automatic wake_ext_seq(string tag, int m);
      irq_ext = 1'b1;
      tick(2);
      chk_state({tag, " R7 early"}, m, 1'b0);
      tick(1);
      chk_state({tag, " R7 accept"}, 0, 1'b1);
      irq_ext = 1'b0;
   endtask

   task automatic leave_clear();
      clr_on_exit = 1'b1;
      reti = 1'b1;
      tick(1);
      clr_on_exit = 1'b0;
      reti = 1'b0;
      chk_state("R10 same-cycle clear", 0, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 reset", 0, 1'b0);

      for (int m = 0; m < 4; m++) begin
         for (int src = 0; src < 2; src++) begin
            for (int clr = 0; clr < 2; clr++) begin
               request(m);
               chk_state("R2 R3 R4 R5 R6 level entry", m, 1'b0);
               if (src == 1 && m == 3) begin
                  irq_int = 1'b1;
                  for (int k = 0; k < 4; k++) begin
                     tick(1);
                     chk_state("R8 deep ignores internal", 3, 1'b0);
                  end
                  irq_int = 1'b0;
               end
               if (src == 0 || m == 3) begin
                  wake_ext_seq("ext", m);
               end else begin
                  irq_int = 1'b1;
                  tick(1);
                  chk_state("R8 internal accept", 0, 1'b1);
                  irq_int = 1'b0;
               end
               tick(1);
               chk_state("R7 single pulse", 0, 1'b0);
               // R11: no new acceptance or level change while in service
               irq_int = 1'b1;
               mode_req_vld = 1'b1;
               mode_req = 2'd3;
               tick(2);
               irq_int = 1'b0;
               mode_req_vld = 1'b0;
               chk_state("R11 in service", 0, 1'b0);
               tick(2);
               if (clr == 1) begin
                  clr_on_exit = 1'b1;
                  tick(1);
                  clr_on_exit = 1'b0;
                  chk_state("R10 clear keeps running", 0, 1'b0);
               end
               reti = 1'b1;
               tick(1);
               reti = 1'b0;
               chk_state(clr == 1 ? "R10 resume running" : "R9 restore level",
                         clr == 1 ? 0 : m, 1'b0);
               if (clr == 0 && m != 0) begin
                  reti = 1'b1;
                  clr_on_exit = 1'b1;
                  tick(2);
                  reti = 1'b0;
                  clr_on_exit = 1'b0;
                  chk_state("R12 stray strobes", m, 1'b0);
                  wake_ext_seq("recover", m);
                  tick(3);
                  leave_clear();
               end
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule